// File: doc/BRIEF.md
# Pulse-Repetition Averaging Sequencer

This block is the timing controller for a coherent averaging run. At the start of a run it takes in four settings: the number of scans to average, the number of samples in each record, the pulse repetition period in clock cycles and the width of the trigger pulse. For each scan it raises a transducer trigger, then opens an acquisition window that lasts one record. During that window it presents a rotated accumulation address, and it then waits out the rest of the period. When the last scan has finished, it sweeps a readout address over the whole record so that a divider can process each accumulated sum. It then raises a ready flag.

The accumulation address for scan k and sample c is (2k + c) modulo the memory depth. The readout address uses the same rotation with the scan term fixed at the average count. The arithmetic itself sits outside this block. The block only sequences enables and addresses. A start request is checked against the legal ranges. A bad request raises an error flag and no run begins.

Top module: `avg_sequencer`

## Requirements
- R1: After reset all enables, windows, the ready flag and the error flag are low.
- R2: A start request is acted on only while the block is idle or done. A start during a run or readout leaves the run unchanged.
- R3: A start is rejected when any of these holds: average count is 0 or above NR/2; trigger width is 0; record length is 0 or above NR; period is below trigger width + record length + 1. A rejected start sets `cfg_err` from the next cycle, and no window opens. A later valid start clears `cfg_err`.
- R4: Each scan begins with `trig` high for exactly the programmed trigger width (1 to 15 cycles). The first scan begins in the cycle after the accepted start.
- R5: `acq_win` is high for exactly record-length cycles, starting in the cycle after `trig` falls.
- R6: Each scan lasts exactly one period P. `scan_win` is high for P−1 cycles and low for one cycle, and the next scan's trigger follows that cycle.
- R7: `run_win` is high for exactly average-count × P consecutive cycles.
- R8: `scan_idx` runs 0, 1, … up to count−1 and holds its value within a scan.
- R9: While `acq_win` is high, `acc_addr` = (2·scan_idx + c) mod NR, where c counts the samples 0 … length−1.
- R10: After the last scan, `rd_en` is high for record-length cycles. During them `rd_addr` = 2·count + c, with NR subtracted when that sum is NR or more.
- R11: `ready` rises in the cycle after the last readout cycle. It stays high until the next start request.
- R12: All four settings are captured at an accepted start. Later changes on the inputs affect only the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request |
| cfg_navg | input | NA_W | Number of scans to average |
| cfg_prt | input | PRT_W | Repetition period in cycles |
| cfg_trig_w | input | TW_W | Trigger pulse width in cycles |
| cfg_len | input | AW+1 | Samples per record |
| trig | output | 1 | Transducer trigger |
| run_win | output | 1 | Whole-run window |
| scan_win | output | 1 | Per-scan repetition window |
| acq_win | output | 1 | Acquisition window / accumulate enable |
| scan_idx | output | NA_W | Current scan number |
| acc_addr | output | AW | Rotated accumulation address |
| rd_en | output | 1 | Readout enable for the divider |
| rd_addr | output | AW | Rotated readout address |
| ready | output | 1 | Run and readout complete |
| cfg_err | output | 1 | Last start request rejected |

## Verification
Every output is a register or a decode of one, so every result is due in the cycle that follows the sampling edge. Call t = 0 the cycle right after the edge that accepts a start. In that frame, the phase of cycle t is t mod P, the scan number is t div P, readout occupies the `len` cycles from count·P onward, and `ready` holds from count·P + `len` on. The bench drives inputs and samples outputs on the falling edge. It compares every output against this closed-form schedule in every cycle of each run. For a rejected start it checks `cfg_err` in the first falling edge after the request.

// File: rtl/avg_sequencer.sv
module avg_sequencer #(
  parameter int NR = 64,
  parameter int PRT_W = 16,
  parameter int TW_W = 4,
  localparam int AW = $clog2(NR),
  localparam int LEN_W = AW + 1,
  localparam int NA_W = $clog2(NR / 2 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NA_W-1:0]  cfg_navg,
  input  logic [PRT_W-1:0] cfg_prt,
  input  logic [TW_W-1:0]  cfg_trig_w,
  input  logic [LEN_W-1:0] cfg_len,
  output logic             trig,
  output logic             run_win,
  output logic             scan_win,
  output logic             acq_win,
  output logic [NA_W-1:0]  scan_idx,
  output logic [AW-1:0]    acc_addr,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             ready,
  output logic             cfg_err
);

  localparam int SW = AW + 2;
  localparam int CW = PRT_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_TRIG, S_ACQ, S_WAIT, S_NEXT, S_READ, S_DONE} st_t;

  st_t              st_q;
  logic [PRT_W-1:0] tick_q, prt_q;
  logic [AW-1:0]    c_q;
  logic [NA_W-1:0]  scan_q, navg_q;
  logic [TW_W-1:0]  tw_q;
  logic [LEN_W-1:0] len_q;
  logic             err_q;

  logic cfg_ok;
  assign cfg_ok = (cfg_navg != '0) && (cfg_navg <= NA_W'(NR / 2)) &&
                  (cfg_trig_w != '0) &&
                  (cfg_len != '0) && (cfg_len <= LEN_W'(NR)) &&
                  (CW'(cfg_prt) >= CW'(cfg_trig_w) + CW'(cfg_len) + CW'(1));

  logic             last_c;
  logic [SW-1:0]    acc_sum, rd_sum;
  assign last_c  = (c_q == AW'(len_q - LEN_W'(1)));
  assign acc_sum = SW'({scan_q, 1'b0}) + SW'(c_q);
  assign rd_sum  = SW'({navg_q, 1'b0}) + SW'(c_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tick_q <= '0;
      c_q    <= '0;
      scan_q <= '0;
      err_q  <= 1'b0;
      navg_q <= '0;
      prt_q  <= '0;
      tw_q   <= '0;
      len_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE, S_DONE: if (start) begin
          if (cfg_ok) begin
            navg_q <= cfg_navg;
            prt_q  <= cfg_prt;
            tw_q   <= cfg_trig_w;
            len_q  <= cfg_len;
            tick_q <= '0;
            c_q    <= '0;
            scan_q <= '0;
            err_q  <= 1'b0;
            st_q   <= S_TRIG;
          end else begin
            err_q <= 1'b1;
            st_q  <= S_IDLE;
          end
        end
        S_TRIG: begin
          tick_q <= tick_q + PRT_W'(1);
          if (tick_q == PRT_W'(tw_q) - PRT_W'(1)) st_q <= S_ACQ;
        end
        S_ACQ: begin
          tick_q <= tick_q + PRT_W'(1);
          if (last_c) begin
            c_q  <= '0;
            st_q <= (tick_q == prt_q - PRT_W'(2)) ? S_NEXT : S_WAIT;
          end else begin
            c_q <= c_q + AW'(1);
          end
        end
        S_WAIT: begin
          tick_q <= tick_q + PRT_W'(1);
          if (tick_q == prt_q - PRT_W'(2)) st_q <= S_NEXT;
        end
        S_NEXT: begin
          tick_q <= '0;
          c_q    <= '0;
          if (scan_q == navg_q - NA_W'(1)) begin
            st_q <= S_READ;
          end else begin
            scan_q <= scan_q + NA_W'(1);
            st_q   <= S_TRIG;
          end
        end
        S_READ: begin
          if (last_c) st_q <= S_DONE;
          else        c_q  <= c_q + AW'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign trig     = (st_q == S_TRIG);
  assign acq_win  = (st_q == S_ACQ);
  assign scan_win = (st_q == S_TRIG) || (st_q == S_ACQ) || (st_q == S_WAIT);
  assign run_win  = scan_win || (st_q == S_NEXT);
  assign rd_en    = (st_q == S_READ);
  assign ready    = (st_q == S_DONE);
  assign cfg_err  = err_q;
  assign scan_idx = scan_q;
  assign acc_addr = (acc_sum >= SW'(NR)) ? AW'(acc_sum - SW'(NR)) : AW'(acc_sum);
  assign rd_addr  = (rd_sum >= SW'(NR)) ? AW'(rd_sum - SW'(NR)) : AW'(rd_sum);

  assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_win && start) |=> run_win);

  assert_err_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !run_win && !rd_en);

  assert_acq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig) |-> acq_win);

  assert_scan_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_win && $past(scan_win)) |-> scan_idx == $past(scan_idx));

  assert_acc_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_win) |-> acc_addr == AW'({scan_idx, 1'b0}));

  assert_rd_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> int'(rd_addr) == (2 * int'(scan_idx) + 2) % NR);

  assert_rd_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |->
      int'(rd_addr) == (int'($past(rd_addr)) + 1) % NR);

  assert_ready_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start) |=> ready);

endmodule

// File: tb/avg_sequencer_bench.sv
`timescale 1ns/1ps
module avg_sequencer_bench;
  localparam int NR = 64;
  localparam int PRT_W = 16;
  localparam int TW_W = 4;
  localparam int AW = $clog2(NR);
  localparam int LEN_W = AW + 1;
  localparam int NA_W = $clog2(NR / 2 + 1);
  localparam int NV = 6;
  // columns: count, period, trigger width, length, start-injection cycle (-1 none)
  localparam int VEC [NV][5] = '{
    '{1, 20, 1, 8, -1},
    '{3, 16, 2, 5, 4},
    '{2, 24, 15, 4, -1},
    '{32, 10, 1, 8, -1},
    '{5, 9, 3, 5, 47},
    '{2, 70, 4, 64, -1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NA_W-1:0]  cfg_navg = '0;
  logic [PRT_W-1:0] cfg_prt = '0;
  logic [TW_W-1:0]  cfg_trig_w = '0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic trig, run_win, scan_win, acq_win, rd_en, ready, cfg_err;
  logic [NA_W-1:0] scan_idx;
  logic [AW-1:0] acc_addr, rd_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  avg_sequencer #(.NR(NR), .PRT_W(PRT_W), .TW_W(TW_W)) u_avg_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_navg(cfg_navg), .cfg_prt(cfg_prt), .cfg_trig_w(cfg_trig_w), .cfg_len(cfg_len),
    .trig(trig), .run_win(run_win), .scan_win(scan_win), .acq_win(acq_win),
    .scan_idx(scan_idx), .acc_addr(acc_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .ready(ready), .cfg_err(cfg_err)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic set_cfg(input int n, input int p, input int w, input int l);
    cfg_navg   = NA_W'(n);
    cfg_prt    = PRT_W'(p);
    cfg_trig_w = TW_W'(w);
    cfg_len    = LEN_W'(l);
  endtask

  task automatic run_vec(input int n, input int p, input int w, input int l, input int inj);
    int total;
    total = n * p + l + 4;
    set_cfg(n, p, w, l);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < total; t++) begin
      int ph, sc, r;
      bit in_run, e_acq, e_rd;
      in_run = (t < n * p);
      ph = t % p;
      sc = t / p;
      r = t - n * p;
      e_acq = in_run && ph >= w && ph < w + l;
      e_rd = !in_run && r < l;
      chk("R4 trig", int'(trig), int'(in_run && ph < w));
      chk("R5 acq_win", int'(acq_win), int'(e_acq));
      chk("R6 scan_win", int'(scan_win), int'(in_run && ph < p - 1));
      chk("R7 run_win", int'(run_win), int'(in_run));
      chk("R10 rd_en", int'(rd_en), int'(e_rd));
      chk("R11 ready", int'(ready), int'(!in_run && r >= l));
      chk("R3 cfg_err clear", int'(cfg_err), 0);
      if (in_run) chk("R8 scan_idx", int'(scan_idx), sc);
      if (e_acq) chk("R9 acc_addr", int'(acc_addr), (2 * sc + ph - w) % NR);
      if (e_rd) chk("R10 rd_addr", int'(rd_addr), (2 * n + r) % NR);
      if (inj >= 0 && t == inj) begin
        start = 1'b1;
        set_cfg(1, 40, 2, 3);
      end
      if (inj >= 0 && t == inj + 1) start = 1'b0;
      @(negedge clk);
    end
    if (inj >= 0) chk("R2 R12 injected start left run intact", int'(ready), 1);
  endtask

  task automatic try_bad(input int n, input int p, input int w, input int l, input string tag);
    set_cfg(n, p, w, l);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({"R3 cfg_err ", tag}, int'(cfg_err), 1);
    chk("R11 ready cleared by start", int'(ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk({"R3 no run ", tag}, int'(run_win | trig | rd_en), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 trig", int'(trig), 0);
    chk("R1 run_win", int'(run_win), 0);
    chk("R1 rd_en", int'(rd_en), 0);
    chk("R1 ready", int'(ready), 0);
    chk("R1 cfg_err", int'(cfg_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", int'(run_win | acq_win | ready), 0);

    for (int i = 0; i < NV; i++)
      run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);

    try_bad(0, 20, 1, 4, "zero count");
    try_bad(33, 20, 1, 4, "count above NR/2");
    try_bad(2, 20, 0, 4, "zero trigger width");
    try_bad(2, 20, 1, 0, "zero length");
    try_bad(2, 80, 1, 65, "length above NR");
    try_bad(2, 10, 4, 6, "period too short");

    run_vec(2, 12, 1, 3, -1);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule